// File: doc/BRIEF.md
# Bus Master Request Handshake

This block is the master-side arbitration front end of an agent that has to win a shared address bus before it can issue a transaction. When the agent's internal logic raises an access request, the block either starts at once (when the arbiter already parks the grant on this agent and nobody holds the bus) or raises a bus request and waits. It waits until the grant is asserted while the shared address-busy line is negated, a qualified grant. In the start cycle it drops the request, drives address-busy, pulses transfer-start and turns on its address drivers, all together.

The block keeps address-busy asserted for the whole address tenure, until the transaction-done input arrives. If another access is already pending at that moment and the grant is still present, the block keeps the bus without releasing address-busy and starts the next transaction on the following clock. All outputs come straight from a state register, so they are free of combinational paths from the bus inputs.

Top module: `bus_master_handshake`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all four outputs are low.
- R2: If an internal request is present without a qualified grant, `bus_req_o` is high from the next clock. It stays high for as long as the internal request stays high and no qualified grant has been sampled.
- R3: A grant sampled while `abb_i` is high does not start a transaction. A start from an idle bus needs `grant_i`=1 and `abb_i`=0 on the previous edge.
- R4: The start cycle is the clock after the edge that samples the qualified grant. In that cycle `bus_req_o`=0 and `abb_drive_o`, `xfer_start_o` and `addr_en_o` are all 1.
- R5: `xfer_start_o` is high for exactly one clock per transaction.
- R6: `abb_drive_o` and `addr_en_o` stay high after the start cycle until `done_i` is sampled. Both are low the clock after that edge, unless R10 applies.
- R7: If the grant is parked on the agent (`grant_i`=1, `abb_i`=0) when the internal request appears, the transaction starts with `bus_req_o` never asserted.
- R8: Withdrawing the grant while the agent is waiting keeps `bus_req_o` high, and no transaction starts.
- R9: If the internal request drops before a qualified grant, `bus_req_o` goes low on the next clock and no transaction starts, even when a qualified grant is present in that same cycle.
- R10: If `done_i` is sampled while another access is pending and `grant_i` is high, `abb_drive_o` stays high. A new one-cycle `xfer_start_o` follows on the next clock.
- R11: If `done_i` is sampled with an access pending but `grant_i` low, the block releases `abb_drive_o` and `addr_en_o` and asserts `bus_req_o` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req_i | input | 1 | Internal access pending. An access is consumed by the start cycle. During the tenure, a high level means a further access is queued. |
| grant_i | input | 1 | Bus grant from the arbiter |
| abb_i | input | 1 | Shared address-busy line as seen at the pin (including this agent's own drive) |
| done_i | input | 1 | Current transaction has terminated (valid only after the start cycle) |
| bus_req_o | output | 1 | Bus request to the arbiter |
| abb_drive_o | output | 1 | Drive enable for asserting address-busy |
| xfer_start_o | output | 1 | One-clock transfer-start pulse |
| addr_en_o | output | 1 | Address driver enable |

## Verification
The assertions assume that `done_i` is raised only during the tenure and never in the start cycle itself. They also assume that the internal requester treats the start pulse as accepting its access, so a level held after it means a new access. The directed tasks keep to both rules: each one pulses `done_i` only once the hold state has been reached, and drops `acc_req_i` in the cycle right after a start unless it is testing chaining. The bench models the shared address-busy wire as the OR of an external holder and the block's own drive. The assertions can therefore rely on `abb_i` being high whenever the block itself owns the bus.

// File: rtl/bmh_pkg.sv
package bmh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_START = 2'd2,
        ST_HOLD  = 2'd3
    } bmh_state_t;

    typedef struct packed {
        logic bus_req;
        logic abb;
        logic start;
        logic addr_en;
    } bmh_out_t;

    typedef struct packed {
        logic want;
        logic grant;
        logic qual;
        logic done;
    } bmh_in_t;

    function automatic logic qualified(input logic grant, input logic busy);
        return grant & ~busy;
    endfunction

    function automatic bmh_out_t decode(input bmh_state_t st);
        bmh_out_t o;
        o.bus_req = (st == ST_WAIT);
        o.abb     = (st == ST_START) || (st == ST_HOLD);
        o.start   = (st == ST_START);
        o.addr_en = (st == ST_START) || (st == ST_HOLD);
        return o;
    endfunction

endpackage

// File: rtl/bmh_qualify.sv
module bmh_qualify
    import bmh_pkg::*;
(
    input  logic    acc_req_i,
    input  logic    grant_i,
    input  logic    abb_i,
    input  logic    done_i,
    output bmh_in_t in_o
);
    always_comb begin
        in_o.want  = acc_req_i;
        in_o.grant = grant_i;
        in_o.qual  = qualified(grant_i, abb_i);
        in_o.done  = done_i;
    end
endmodule

// File: rtl/bmh_fsm.sv
module bmh_fsm
    import bmh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bmh_in_t    in_i,
    output bmh_state_t state_o
);
    bmh_state_t state_q;
    bmh_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_i.want && in_i.qual)      state_d = ST_START;
                else if (in_i.want)              state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!in_i.want)                  state_d = ST_IDLE;
                else if (in_i.qual)              state_d = ST_START;
            end
            ST_START: begin
                state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (in_i.done) begin
                    if (in_i.want && in_i.grant) state_d = ST_START;
                    else if (in_i.want)          state_d = ST_WAIT;
                    else                         state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

    // R5: a start state is always followed by the hold state
    p_start_once_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START) |=> (state_q == ST_HOLD));

    // R9: losing the internal request while waiting returns to idle
    p_cancel_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !in_i.want) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/bmh_drive.sv
module bmh_drive
    import bmh_pkg::*;
(
    input  bmh_state_t state_i,
    output bmh_out_t   out_o
);
    always_comb out_o = decode(state_i);
endmodule

// File: rtl/bus_master_handshake.sv
module bus_master_handshake
    import bmh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acc_req_i,
    input  logic grant_i,
    input  logic abb_i,
    input  logic done_i,
    output logic bus_req_o,
    output logic abb_drive_o,
    output logic xfer_start_o,
    output logic addr_en_o
);
    bmh_in_t    sampled;
    bmh_state_t state;
    bmh_out_t   outs;

    bmh_qualify u_qual (
        .acc_req_i (acc_req_i),
        .grant_i   (grant_i),
        .abb_i     (abb_i),
        .done_i    (done_i),
        .in_o      (sampled)
    );

    bmh_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .in_i    (sampled),
        .state_o (state)
    );

    bmh_drive u_drive (
        .state_i (state),
        .out_o   (outs)
    );

    assign bus_req_o    = outs.bus_req;
    assign abb_drive_o  = outs.abb;
    assign xfer_start_o = outs.start;
    assign addr_en_o    = outs.addr_en;

    // R3: a start from an unowned bus needs a qualified grant on the prior edge
    p_qual_start_r3: assert property (@(posedge clk) disable iff (rst)
        (!abb_drive_o && acc_req_i && !(grant_i && !abb_i)) |=> !xfer_start_o);

    // R5: transfer-start never lasts two clocks
    p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_start_o |=> !xfer_start_o);

    // R6: tenure is held until done is sampled
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (abb_drive_o && !xfer_start_o && !done_i) |=> (abb_drive_o && addr_en_o));

    // R8: grant withdrawal while waiting keeps the request up
    p_keep_req_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && acc_req_i && !grant_i) |=> (bus_req_o && !xfer_start_o));

    // R10: chained transaction keeps address-busy asserted
    p_chain_r10: assert property (@(posedge clk) disable iff (rst)
        (abb_drive_o && !xfer_start_o && done_i && acc_req_i && grant_i)
            |=> (xfer_start_o && abb_drive_o));

    // R11: done with a pending access but no grant goes back to requesting
    p_rereq_r11: assert property (@(posedge clk) disable iff (rst)
        (abb_drive_o && !xfer_start_o && done_i && acc_req_i && !grant_i)
            |=> (bus_req_o && !abb_drive_o));
endmodule

// File: tb/bus_master_handshake_tb.sv
module bus_master_handshake_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_req = 1'b0;
    logic grant = 1'b0;
    logic ext_abb = 1'b0;
    logic done = 1'b0;
    logic abb_line;
    logic bus_req, abb_drive, xfer_start, addr_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    assign abb_line = ext_abb | abb_drive;

    bus_master_handshake dut_i (
        .clk          (clk),
        .rst          (rst),
        .acc_req_i    (acc_req),
        .grant_i      (grant),
        .abb_i        (abb_line),
        .done_i       (done),
        .bus_req_o    (bus_req),
        .abb_drive_o  (abb_drive),
        .xfer_start_o (xfer_start),
        .addr_en_o    (addr_en)
    );

    // {bus_req, abb_drive, xfer_start, addr_en}
    localparam logic [3:0] O_IDLE  = 4'b0000;
    localparam logic [3:0] O_WAIT  = 4'b1000;
    localparam logic [3:0] O_START = 4'b0111;
    localparam logic [3:0] O_HOLD  = 4'b0101;

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {bus_req, abb_drive, xfer_start, addr_en};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic g, input logic b, input logic d);
        acc_req = r; grant = g; ext_abb = b; done = d;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 during reset", O_IDLE);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", O_IDLE);
    endtask

    task automatic t_parked();
        step(1, 1, 0, 0); check("R7 parked start no request", O_START);
        step(0, 1, 0, 0); check("R5 start single cycle", O_HOLD);
        step(0, 1, 0, 0); check("R6 tenure held", O_HOLD);
        step(0, 1, 0, 1); check("R6 release after done", O_IDLE);
        step(0, 1, 0, 0); check("R6 stays idle", O_IDLE);
    endtask

    task automatic t_wait();
        step(1, 0, 0, 0); check("R2 request raised", O_WAIT);
        step(1, 1, 1, 0); check("R3 busy blocks grant", O_WAIT);
        step(1, 0, 0, 0); check("R8 grant removed keeps request", O_WAIT);
        step(1, 1, 0, 0); check("R4 start on qualified grant", O_START);
        step(0, 0, 0, 0); check("R5 pulse ends", O_HOLD);
        step(0, 0, 0, 1); check("R6 release", O_IDLE);
    endtask

    task automatic t_cancel();
        step(1, 0, 0, 0); check("R2 request raised", O_WAIT);
        step(0, 1, 0, 0); check("R9 cancel drops request", O_IDLE);
        step(0, 1, 0, 0); check("R9 no start after cancel", O_IDLE);
    endtask

    task automatic t_chain();
        step(1, 1, 0, 0); check("R4 first start", O_START);
        step(0, 1, 0, 0); check("R5 first pulse ends", O_HOLD);
        step(1, 1, 0, 1); check("R10 chained start keeps busy", O_START);
        step(0, 1, 0, 0); check("R10 second tenure", O_HOLD);
        step(0, 1, 0, 1); check("R6 release after chain", O_IDLE);
    endtask

    task automatic t_rereq();
        step(1, 1, 0, 0); check("R4 start", O_START);
        step(0, 1, 0, 0); check("R5 hold", O_HOLD);
        step(1, 0, 0, 1); check("R11 release and re-request", O_WAIT);
        step(1, 1, 0, 0); check("R11 restart on grant", O_START);
        step(0, 1, 0, 0); check("R5 hold", O_HOLD);
        step(0, 1, 0, 1); check("R6 release", O_IDLE);
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: cycles=%0d expected=<20000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_parked();
        t_wait();
        t_cancel();
        t_chain();
        t_rereq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule